// File: doc/BRIEF.md
# SDRAM Periodic Refresh Controller

This block produces the refresh traffic that an SDRAM controller must issue on a schedule. A free-running prescaler gives a slower tick. The tick drives an up-counter that is compared on every cycle with a programmed constant. When the two are equal, the counter restarts from zero and one refresh request is recorded. While the memory interface is granted by the access arbiter, a sequencer serves each recorded request. It runs a burst of refresh operations. Each operation is a precharge-all command, an optional idle gap, an auto-refresh command and an optional lockout gap.

Two mode inputs pick the behaviour. Auto-refresh runs the timer-driven bursts. Self-refresh precharges all banks and then enters the low-power state with CKE held low. The controller holds this state until the mode is cleared. Read and write sequencing, mode-register setup and bus access lie outside this block.

Sequencer states: IDLE (waits for work and a grant), PALL (the precharge-all cycle), PGAP (idle cycles after precharge), REF (the refresh cycle), RECOV (lockout cycles after refresh) and SELF (CKE held low). Transitions: IDLE→PALL on a grant with work to do. PALL→REF when the precharge wait is zero, otherwise PALL→PGAP. PGAP→REF when the wait ends. In a self-refresh entry REF→SELF. Otherwise REF→RECOV when the recovery wait is nonzero, and otherwise REF goes straight to the next PALL or to IDLE. RECOV→PALL or RECOV→IDLE when the wait ends. SELF→IDLE when self-refresh mode is cleared.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: Auto-refresh mode is active when rf_enable=1 and rf_selfmode=0, and self-refresh mode is active when both are 1. With rf_enable=0, a timer match creates no request and issues no command.
- R2: When clk_sel=0 the timer count holds. A cnt_wr pulse loads cnt_wdata into the count on the next edge. Once a nonzero clk_sel is selected, counting resumes from the held value.
- R3: The clk_sel codes 1 to 7 advance the count once every 4, 16, 64, 256, 1024, 2048 or 4096 clock cycles respectively.
- R4: While the timer runs and the count equals cmp_val, one refresh request is recorded and the count clears to 0 on the same edge.
- R5: Each served request runs a burst of refresh operations. The burst_code values 0, 1, 2 and 3 give 1, 2, 4 and 6 operations, and codes 4 to 7 give 8.
- R6: Each operation starts with one precharge-all cycle: {cs_n,ras_n,cas_n,we_n}=0010 with sd_a10=1.
- R7: Exactly twait_pre idle cycles lie between the precharge-all cycle and the refresh cycle, and none when twait_pre=0.
- R8: The refresh cycle drives 0001 with sd_cke=1 in auto-refresh mode.
- R9: After each refresh cycle exactly twait_rec NOP cycles pass before the next command or the end of the burst.
- R10: Work starts only while arb_grant=1. rf_req is high while work waits in IDLE. rf_busy is high from the precharge-all cycle until the last lockout cycle of the burst ends.
- R11: Requests not yet served are counted up to 7. Further matches are dropped.
- R12: Self-refresh issues a precharge-all, then after twait_pre idle cycles a 0001 command with sd_cke=0. sd_cke stays low and rf_busy stays high until self-refresh mode is cleared, and then both return in the next cycle.
- R13: In every cycle without a command the outputs drive NOP, 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_enable | input | 1 | Refresh enable |
| rf_selfmode | input | 1 | Mode bit: 0 auto, 1 self-refresh |
| clk_sel | input | 3 | Timer clock select, 0 stops the timer |
| cnt_wr | input | 1 | Load strobe for the timer count |
| cnt_wdata | input | CNT_W | Value loaded into the count |
| cmp_val | input | CNT_W | Compare constant |
| burst_code | input | 3 | Refreshes per request code |
| twait_pre | input | 2 | Idle cycles after precharge-all |
| twait_rec | input | 2 | Lockout cycles after refresh |
| arb_grant | input | 1 | Memory interface granted |
| rf_req | output | 1 | Refresh work waiting |
| rf_busy | output | 1 | Sequencer owns the interface |
| timer_count | output | CNT_W | Current timer count |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Address bit 10 (all-bank precharge) |
| sd_cke | output | 1 | Clock enable |

## Verification
The bench measures the exact number of idle cycles on each side of the refresh command for zero and nonzero wait fields. A design with an off-by-one gap, or one that inserts a gap when the field is zero, shows a wrong count. It counts the refresh commands for several burst codes, including codes above 4, so a wrong code mapping or a burst that stops one operation early or late gives the wrong total. It queues nine matches while the grant is withheld, and a pending counter without a cap would wrap or overrun and serve the wrong number of bursts. It also walks the timer through stop, load and two dividers, and walks self-refresh entry and exit, where a CKE held low too long or released too early shows at the pins.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PALL,
        ST_PGAP,
        ST_REF,
        ST_RECOV,
        ST_SELF
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PALL = 4'b0010;
    localparam logic [3:0] CMD_REF  = 4'b0001;

    function automatic logic [3:0] burst_len(input logic [2:0] code);
        case (code)
            3'd0:    burst_len = 4'd1;
            3'd1:    burst_len = 4'd2;
            3'd2:    burst_len = 4'd4;
            3'd3:    burst_len = 4'd6;
            default: burst_len = 4'd8;
        endcase
    endfunction

    // log2 of the prescale ratio; 0 means stopped
    function automatic logic [3:0] div_shift(input logic [2:0] sel);
        case (sel)
            3'd1:    div_shift = 4'd2;
            3'd2:    div_shift = 4'd4;
            3'd3:    div_shift = 4'd6;
            3'd4:    div_shift = 4'd8;
            3'd5:    div_shift = 4'd10;
            3'd6:    div_shift = 4'd11;
            3'd7:    div_shift = 4'd12;
            default: div_shift = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer
    import sdr_refresh_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             match
);

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    logic [3:0]       shift;
    logic             running;
    logic             tick;

    assign shift   = div_shift(clk_sel);
    assign running = (clk_sel != 3'd0);

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(shift));
        end
    end

    assign tick  = running && ((pre & mask) == mask);
    assign match = running && (count == cmp_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= cnt_wdata;
        end else if (match) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
    import sdr_refresh_pkg::*;
#(
    parameter int PEND_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       self_mode,
    input  logic       match,
    input  logic [2:0] burst_code,
    input  logic [1:0] twait_pre,
    input  logic [1:0] twait_rec,
    input  logic       grant,
    output logic       req,
    output logic       busy,
    output logic [3:0] cmd,
    output logic       a10,
    output logic       cke
);

    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    seq_state_t        state, state_nx;
    logic [PEND_W-1:0] pend;
    logic [1:0]        wcnt;
    logic [3:0]        left;
    logic              self_run;
    logic              take, add;

    assign take = (state == ST_IDLE) && grant && !self_mode && auto_mode && (pend != '0);
    assign add  = match && auto_mode && ((pend != PEND_MAX) || take);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (add && !take) begin
            pend <= pend + 1'b1;
        end else if (take && !add) begin
            pend <= pend - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if ((grant && self_mode) || take) state_nx = ST_PALL;
            ST_PALL:  state_nx = (twait_pre == 2'd0) ? ST_REF : ST_PGAP;
            ST_PGAP:  if (wcnt == 2'd1) state_nx = ST_REF;
            ST_REF: begin
                if (self_run)                state_nx = ST_SELF;
                else if (twait_rec != 2'd0)  state_nx = ST_RECOV;
                else if (left != 4'd0)       state_nx = ST_PALL;
                else                         state_nx = ST_IDLE;
            end
            ST_RECOV: if (wcnt == 2'd1) state_nx = (left != 4'd0) ? ST_PALL : ST_IDLE;
            ST_SELF:  if (!self_mode) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register with its wait and burst counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wcnt     <= '0;
            left     <= '0;
            self_run <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (grant && self_mode) begin
                        self_run <= 1'b1;
                        left     <= '0;
                    end else if (take) begin
                        self_run <= 1'b0;
                        left     <= burst_len(burst_code) - 4'd1;
                    end
                end
                ST_PALL:  wcnt <= twait_pre;
                ST_PGAP:  wcnt <= wcnt - 2'd1;
                ST_REF: begin
                    wcnt <= twait_rec;
                    if (!self_run && twait_rec == 2'd0 && left != 4'd0) left <= left - 4'd1;
                end
                ST_RECOV: begin
                    wcnt <= wcnt - 2'd1;
                    if (wcnt == 2'd1 && left != 4'd0) left <= left - 4'd1;
                end
                ST_SELF:  if (!self_mode) self_run <= 1'b0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd  = CMD_NOP;
        a10  = 1'b0;
        cke  = 1'b1;
        busy = (state != ST_IDLE);
        req  = (state == ST_IDLE) && (self_mode || (auto_mode && pend != '0));
        unique case (state)
            ST_PALL: begin
                cmd = CMD_PALL;
                a10 = 1'b1;
            end
            ST_REF: begin
                cmd = CMD_REF;
                cke = !self_run;
            end
            ST_SELF: cke = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
    import sdr_refresh_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rf_enable,
    input  logic             rf_selfmode,
    input  logic [2:0]       clk_sel,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [2:0]       burst_code,
    input  logic [1:0]       twait_pre,
    input  logic [1:0]       twait_rec,
    input  logic             arb_grant,
    output logic             rf_req,
    output logic             rf_busy,
    output logic [CNT_W-1:0] timer_count,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic             sd_a10,
    output logic             sd_cke
);

    logic       match;
    logic       auto_mode, self_mode;
    logic [3:0] cmd;

    assign auto_mode = rf_enable && !rf_selfmode;
    assign self_mode = rf_enable && rf_selfmode;

    refresh_timer #(.CNT_W(CNT_W), .PRE_W(12)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_val   (cmp_val),
        .count     (timer_count),
        .match     (match)
    );

    refresh_seq #(.PEND_W(PEND_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_mode  (auto_mode),
        .self_mode  (self_mode),
        .match      (match),
        .burst_code (burst_code),
        .twait_pre  (twait_pre),
        .twait_rec  (twait_rec),
        .grant      (arb_grant),
        .req        (rf_req),
        .busy       (rf_busy),
        .cmd        (cmd),
        .a10        (sd_a10),
        .cke        (sd_cke)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/refresh_chk.sv
module refresh_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] twait_pre,
    input logic       arb_grant,
    input logic       rf_req,
    input logic       rf_busy,
    input logic       sd_cs_n,
    input logic       sd_ras_n,
    input logic       sd_cas_n,
    input logic       sd_we_n,
    input logic       sd_a10,
    input logic       sd_cke
);

    logic [3:0] c;
    assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    a_r6_pall_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> sd_a10);

    a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010 && twait_pre == 2'd0) |=> (c == 4'b0001));

    a_r10_cmd_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (c != 4'b0111) |-> rf_busy);

    a_r10_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_busy) |-> $past(arb_grant));

    a_r10_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> !rf_busy);

    a_r12_cke_drop_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> (c == 4'b0001));

endmodule

bind sdram_refresh_ctrl refresh_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .twait_pre (twait_pre),
    .arb_grant (arb_grant),
    .rf_req    (rf_req),
    .rf_busy   (rf_busy),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_a10    (sd_a10),
    .sd_cke    (sd_cke)
);

// File: tb/tb_sdram_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_refresh_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rf_enable, rf_selfmode, cnt_wr, arb_grant;
    logic [2:0] clk_sel, burst_code;
    logic [7:0] cnt_wdata, cmp_val;
    logic [1:0] twait_pre, twait_rec;
    logic       rf_req, rf_busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_cke;
    logic [7:0] timer_count;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sdram_refresh_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rf_enable(rf_enable), .rf_selfmode(rf_selfmode),
        .clk_sel(clk_sel), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_val(cmp_val),
        .burst_code(burst_code), .twait_pre(twait_pre), .twait_rec(twait_rec),
        .arb_grant(arb_grant), .rf_req(rf_req), .rf_busy(rf_busy),
        .timer_count(timer_count), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10), .sd_cke(sd_cke)
    );

    function automatic logic [3:0] cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one match: load the compare value while the timer runs
    task automatic fire();
        cnt_wdata = cmp_val;
        cnt_wr    = 1'b1;
        step();
        cnt_wr    = 1'b0;
        step();
    endtask

    task automatic drain();
        clk_sel   = 3'd0;
        arb_grant = 1'b1;
        step(300);
    endtask

    // follow one burst and measure every gap
    task automatic burst_check(input int n, input string tag);
        int w = 0;
        while (cmd() != 4'b0010 && w < 60) begin step(); w++; end
        for (int i = 0; i < n; i++) begin
            int g = 0;
            int r = 0;
            chk({tag, " R6 PALL"}, cmd(), 4'b0010);
            chk({tag, " R6 A10"}, sd_a10, 1);
            chk({tag, " R10 busy"}, rf_busy, 1);
            step();
            while (cmd() == 4'b0111 && g < 8) begin g++; step(); end
            chk({tag, " R7 pre gap"}, g, twait_pre);
            chk({tag, " R8 REF"}, cmd(), 4'b0001);
            chk({tag, " R8 cke"}, sd_cke, 1);
            step();
            while (cmd() == 4'b0111 && rf_busy && r < 8) begin r++; step(); end
            chk({tag, " R9 rec gap"}, r, twait_rec);
        end
        chk({tag, " R5 burst end busy"}, rf_busy, 0);
        chk({tag, " R13 NOP after"}, cmd(), 4'b0111);
    endtask

    task automatic t_reset();
        chk("R13 reset cmd", cmd(), 4'b0111);
        chk("R10 reset busy", rf_busy, 0);
        chk("R10 reset req", rf_req, 0);
        chk("R12 reset cke", sd_cke, 1);
        chk("R2 reset count", timer_count, 0);
    endtask

    task automatic t_burst(input logic [2:0] code, input logic [1:0] p,
                           input logic [1:0] r, input int n, input string tag);
        rf_enable = 1; rf_selfmode = 0; arb_grant = 1;
        burst_code = code; twait_pre = p; twait_rec = r;
        cmp_val = 8'd5; clk_sel = 3'd7;
        fire();
        burst_check(n, tag);
        drain();
    endtask

    task automatic t_timer();
        rf_enable = 0; cmp_val = 8'd200; clk_sel = 3'd0;
        cnt_wdata = 8'd0; cnt_wr = 1; step(); cnt_wr = 0;
        clk_sel = 3'd1; step(8);
        chk("R3 div4 count", timer_count, 2);
        clk_sel = 3'd2; step(32);
        chk("R3 div16 count", timer_count, 4);
        clk_sel = 3'd0; step(20);
        chk("R2 stopped hold", timer_count, 4);
        cnt_wdata = 8'd9; cnt_wr = 1; step(); cnt_wr = 0; step(10);
        chk("R2 load while stopped", timer_count, 9);
        clk_sel = 3'd1; step(8);
        chk("R2 resume from held", timer_count, 11);
        clk_sel = 3'd0;
    endtask

    task automatic t_match();
        int w = 0;
        rf_enable = 1; rf_selfmode = 0; arb_grant = 0;
        cmp_val = 8'd3; clk_sel = 3'd0;
        cnt_wdata = 8'd0; cnt_wr = 1; step(); cnt_wr = 0;
        clk_sel = 3'd1;
        while (!rf_req && w < 40) begin step(); w++; end
        chk("R4 request raised", rf_req, 1);
        chk("R4 count cleared", (timer_count <= 1) ? 1 : 0, 1);
        chk("R10 wait no grant busy", rf_busy, 0);
        step(10);
        chk("R10 no cmd without grant", cmd(), 4'b0111);
        drain();
    endtask

    task automatic t_pending();
        int refs = 0;
        rf_enable = 1; rf_selfmode = 0; arb_grant = 0;
        burst_code = 3'd0; twait_pre = 0; twait_rec = 0;
        cmp_val = 8'd5; clk_sel = 3'd7;
        for (int i = 0; i < 9; i++) fire();
        chk("R10 req while queued", rf_req, 1);
        clk_sel = 3'd0; arb_grant = 1;
        for (int i = 0; i < 200; i++) begin
            step();
            if (cmd() == 4'b0001) refs++;
        end
        chk("R11 capped refresh count", refs, 7);
    endtask

    task automatic t_disabled();
        int refs = 0;
        rf_enable = 0; rf_selfmode = 0; arb_grant = 1;
        cmp_val = 8'd5; clk_sel = 3'd7;
        fire();
        for (int i = 0; i < 30; i++) begin
            step();
            if (cmd() != 4'b0111 || rf_busy || rf_req) refs++;
        end
        chk("R1 disabled ignores match", refs, 0);
        drain();
    endtask

    task automatic t_self();
        int w = 0;
        int low = 0;
        rf_enable = 1; rf_selfmode = 1; arb_grant = 1;
        twait_pre = 2'd1; clk_sel = 3'd0;
        while (cmd() != 4'b0010 && w < 20) begin step(); w++; end
        chk("R12 self PALL", cmd(), 4'b0010);
        step(2);
        chk("R12 self REF", cmd(), 4'b0001);
        chk("R12 self cke low", sd_cke, 0);
        for (int i = 0; i < 20; i++) begin
            step();
            if (!sd_cke && rf_busy && cmd() == 4'b0111) low++;
        end
        chk("R12 cke held low", low, 20);
        rf_selfmode = 0;
        step();
        chk("R12 exit cke", sd_cke, 1);
        chk("R12 exit busy", rf_busy, 0);
        drain();
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; rf_enable = 0; rf_selfmode = 0; clk_sel = 0; cnt_wr = 0;
        cnt_wdata = 0; cmp_val = 8'd5; burst_code = 0; twait_pre = 0; twait_rec = 0;
        arb_grant = 0;
        step(4);
        rst_n = 1;
        step();
        t_reset();
        t_burst(3'd0, 2'd0, 2'd0, 1, "single");
        t_burst(3'd2, 2'd3, 2'd2, 4, "four");
        t_burst(3'd3, 2'd2, 2'd1, 6, "six");
        t_burst(3'd6, 2'd1, 2'd3, 8, "code6");
        t_burst(3'd1, 2'd0, 2'd3, 2, "two");
        t_timer();
        t_match();
        t_pending();
        t_disabled();
        t_self();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule